// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in memory. A requester presents the virtual address together with the frame number of the top-level table (the directory). The walker reads the directory entry selected by the upper index field, then the second-level entry selected by the middle index field, and finally reports either the translated physical address or a fault.

When it reports a fault, the walker also says which level's entry was invalid. Pages are 4 KB, so the low 12 address bits pass through unchanged. Only one walk runs at a time. While a walk is in flight the block refuses new requests.

The block reaches memory through a plain word-read port. It raises a one-cycle read strobe with an address, then waits for a response strobe that may come any number of cycles later. Installing the result in a translation cache is left to the requester. For that purpose the leaf entry's attribute bits are returned with the translation.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `mem_req_valid` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle `mem_req_valid` pulses, with address `{root_frame, vaddr[31:22], 2'b00}`.
- R3: Every memory read is a single-cycle strobe. The walker waits any number of cycles for `mem_rsp_valid`. A `mem_rsp_valid` that arrives while no read is pending has no effect on any output.
- R4: Bit 0 of an entry is its valid bit and bits 31:12 are a frame number. A valid directory entry is followed by exactly one second read, at `{dir[31:12], vaddr[21:12], 2'b00}`.
- R5: An invalid directory entry ends the walk with `resp_fault`=1 and `resp_level`=0 (0 means directory). No second read is issued.
- R6: An invalid second-level entry ends the walk with `resp_fault`=1 and `resp_level`=1 (1 means table).
- R7: A valid second-level entry ends the walk with `resp_fault`=0, `resp_paddr` = `{pte[31:12], vaddr[11:0]}` and `resp_attr` = `pte[11:1]`.
- R8: `resp_valid` is high for exactly one cycle per walk. `req_ready` returns to 1 in the cycle after that.
- R9: From acceptance until `resp_valid`, `req_ready` is 0. Changes on `req_valid`, `req_vaddr` and `root_frame` in that window do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request can be accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| root_frame | input | 20 | Frame number of the directory |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Walk ended on an invalid entry |
| resp_level | output | 1 | Failing level: 0 directory, 1 table |
| resp_paddr | output | 32 | Translated physical address |
| resp_attr | output | 11 | Leaf entry bits 11:1 |
| mem_req_valid | output | 1 | One-cycle memory read strobe |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Entry word read from memory |

## Verification
The bench builds the walker with its default parameters: a 32-bit virtual address split 10/10/12 over two levels, and 32-bit entries. With these values, random addresses reach the whole range of both index fields. The bench's memory derives each word from a hash of its address, with about one word in eight invalid, so successful walks and faults at either level all occur in a run of moderate length. Memory latency varies from zero to three extra cycles, which covers both back-to-back responses and long waits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int IDX_W    = 10;
    localparam int LEVELS   = 2;
    localparam int ENT_W    = 32;
    localparam int ENT_LG   = 2;
    localparam int FRAME_W  = ENT_W - OFF_W;
    localparam int PA_W     = FRAME_W + OFF_W;
    localparam int MADDR_W  = FRAME_W + IDX_W + ENT_LG;
    localparam int ATTR_W   = OFF_W - 1;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int VPN_W    = VA_W - OFF_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_PTE,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef struct packed {
        walk_st_e             st;
        logic                 issue;
        logic [VA_W-1:0]      va;
        logic [FRAME_W-1:0]   frame;
        logic [ATTR_W-1:0]    attr;
        logic [LVL_W-1:0]     level;
    } walk_regs_t;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int FRAME_W = 20,
    parameter int IDX_W   = 10,
    parameter int ENT_LG  = 2,
    localparam int ADDR_W = FRAME_W + IDX_W + ENT_LG
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [ADDR_W-1:0]  addr
);
    // Entries are 2**ENT_LG bytes, packed from the table's frame start.
    assign addr = {frame, idx, {ENT_LG{1'b0}}};
endmodule

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
    parameter int IDX_W  = 10,
    parameter int LEVELS = 2,
    localparam int VPN_W = IDX_W * LEVELS,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_tbl [LEVELS];

    // Level 0 takes the most significant index field.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign idx_tbl[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    assign idx = idx_tbl[level];
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int ENT_W = 32,
    parameter int OFF_W = 12,
    localparam int FRAME_W = ENT_W - OFF_W,
    localparam int ATTR_W  = OFF_W - 1
) (
    input  logic [ENT_W-1:0]   word,
    output logic               valid,
    output logic [FRAME_W-1:0] frame,
    output logic [ATTR_W-1:0]  attr
);
    assign valid = word[0];
    assign attr  = word[OFF_W-1:1];
    assign frame = word[ENT_W-1:OFF_W];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] root_frame,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic [LVL_W-1:0]   resp_level,
    output logic [PA_W-1:0]    resp_paddr,
    output logic [ATTR_W-1:0]  resp_attr,
    output logic               mem_req_valid,
    output logic [MADDR_W-1:0] mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_data
);
    walk_regs_t r_q, r_d;

    logic [IDX_W-1:0]   cur_idx;
    logic               ent_valid;
    logic [FRAME_W-1:0] ent_frame;
    logic [ATTR_W-1:0]  ent_attr;
    logic               rsp_take;

    ptw_index_sel #(.IDX_W(IDX_W), .LEVELS(LEVELS)) u_idx (
        .vpn   (r_q.va[VA_W-1:OFF_W]),
        .level (r_q.level),
        .idx   (cur_idx)
    );

    ptw_entry_addr #(.FRAME_W(FRAME_W), .IDX_W(IDX_W), .ENT_LG(ENT_LG)) u_addr (
        .frame (r_q.frame),
        .idx   (cur_idx),
        .addr  (mem_req_addr)
    );

    ptw_entry_decode #(.ENT_W(ENT_W), .OFF_W(OFF_W)) u_dec (
        .word  (mem_rsp_data),
        .valid (ent_valid),
        .frame (ent_frame),
        .attr  (ent_attr)
    );

    // A response counts only while a read is outstanding, never in its issue cycle.
    assign rsp_take = mem_rsp_valid && !r_q.issue;

    always_comb begin
        r_d       = r_q;
        r_d.issue = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_RD_DIR;
                    r_d.issue = 1'b1;
                    r_d.va    = req_vaddr;
                    r_d.frame = root_frame;
                    r_d.level = '0;
                end
            end
            ST_RD_DIR: begin
                if (rsp_take) begin
                    if (ent_valid) begin
                        r_d.st    = ST_RD_PTE;
                        r_d.issue = 1'b1;
                        r_d.frame = ent_frame;
                        r_d.level = LVL_W'(1);
                    end else begin
                        r_d.st = ST_FAULT;
                    end
                end
            end
            ST_RD_PTE: begin
                if (rsp_take) begin
                    if (ent_valid) begin
                        r_d.st    = ST_DONE;
                        r_d.frame = ent_frame;
                        r_d.attr  = ent_attr;
                    end else begin
                        r_d.st = ST_FAULT;
                    end
                end
            end
            ST_DONE, ST_FAULT: r_d.st = ST_IDLE;
            default:           r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign resp_valid    = (r_q.st == ST_DONE) || (r_q.st == ST_FAULT);
    assign resp_fault    = (r_q.st == ST_FAULT);
    assign resp_level    = r_q.level;
    assign resp_paddr    = {r_q.frame, r_q.va[OFF_W-1:0]};
    assign resp_attr     = r_q.attr;
    assign mem_req_valid = r_q.issue;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_fault,
    input logic               mem_req_valid,
    input logic               mem_rsp_valid,
    input logic [ENT_W-1:0]   mem_rsp_data
);
    logic waiting;
    assign waiting = !req_ready && !mem_req_valid && !resp_valid;

    // R2
    accept_issues_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid && !req_ready));

    // R3
    read_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R4
    valid_entry_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && mem_rsp_valid && mem_rsp_data[0]) |=> (mem_req_valid || (resp_valid && !resp_fault)));

    // R5
    invalid_entry_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && mem_rsp_valid && !mem_rsp_data[0]) |=> (resp_valid && resp_fault));

    // R8
    resp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || resp_valid) |-> !req_ready);
endmodule

bind pt_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_fault    (resp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [19:0] root_frame = '0;
    logic        resp_valid;
    logic        resp_fault;
    logic [0:0]  resp_level;
    logic [31:0] resp_paddr;
    logic [10:0] resp_attr;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_tot = 0;
    int n_fail = 0;
    int n_ok = 0, n_f0 = 0, n_f1 = 0;

    // memory model state
    int          lat = 0;
    bit          inject = 1'b0;
    bit          pend = 1'b0;
    int          cnt = 0;
    logic [31:0] pend_addr = '0;
    int          req_total = 0;
    logic [31:0] prev_addr = '0, last_addr = '0;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_frame(root_frame),
        .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_level(resp_level), .resp_paddr(resp_paddr), .resp_attr(resp_attr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] h;
        h = (a * 32'h9E37_79B1) ^ (a >> 7) ^ 32'h5A5A_1234;
        return {h[31:1], (h[6:4] != 3'b000)};
    endfunction

    always @(negedge clk) begin
        mem_rsp_valid <= inject;
        if (inject) mem_rsp_data <= 32'hFFFF_FFFF;
        if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_word(pend_addr);
                pend <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (mem_req_valid) begin
            pend      <= 1'b1;
            cnt       <= lat;
            pend_addr <= mem_req_addr;
            prev_addr <= last_addr;
            last_addr <= mem_req_addr;
            req_total <= req_total + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [19:0] root, input int l, input bit junk);
        logic [31:0] a0, a1, d, p;
        int start, cyc;
        bit busy_bad;
        a0 = {root, va[31:22], 2'b00};
        d  = mem_word(a0);
        a1 = {d[31:12], va[21:12], 2'b00};
        p  = mem_word(a1);
        @(negedge clk);
        lat = l;
        start = req_total;
        check(req_ready == 1'b1, "R8 ready before walk", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_vaddr = va; root_frame = root;
        @(negedge clk);
        if (junk) begin
            req_vaddr = ~va; root_frame = ~root;
        end else begin
            req_valid = 1'b0;
        end
        cyc = 0; busy_bad = 1'b0;
        while (!resp_valid && cyc < 60) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
            cyc++;
        end
        check(resp_valid == 1'b1, "R3 walk completes", 32'(cyc), 32'd0);
        if (junk) check(!busy_bad, "R9 ready low while busy", 32'(busy_bad), 32'd0);
        check(start + 1 <= req_total && prev_addr == a0 || last_addr == a0 && req_total == start + 1,
              "R2 directory read address", (req_total == start + 1) ? last_addr : prev_addr, a0);
        if (!d[0]) begin
            n_f0++;
            check(req_total == start + 1, "R5 no second read", 32'(req_total - start), 32'd1);
            check(resp_fault && resp_level == 1'b0, "R5 directory fault", {resp_fault, 3'b0, 4'(resp_level)}, 32'h10);
        end else begin
            check(req_total == start + 2 && last_addr == a1, "R4 table read address", last_addr, a1);
            if (!p[0]) begin
                n_f1++;
                check(resp_fault && resp_level == 1'b1, "R6 table fault", {resp_fault, 3'b0, 4'(resp_level)}, 32'h11);
            end else begin
                n_ok++;
                check(!resp_fault && resp_paddr == {p[31:12], va[11:0]}, "R7 physical address",
                      resp_paddr, {p[31:12], va[11:0]});
                check(resp_attr == p[11:1], "R7 attribute bits", 32'(resp_attr), 32'(p[11:1]));
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        check(!resp_valid && req_ready, "R8 single response then ready", {resp_valid, 3'b0, 4'(req_ready)}, 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tot++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        check(!resp_valid && !mem_req_valid, "R1 idle outputs", {resp_valid, 3'b0, 4'(mem_req_valid)}, 32'h0);
        rst_n = 1'b1;

        // directed corners
        walk(32'h0000_0000, 20'h00000, 0, 1'b0);
        walk(32'hFFFF_FFFF, 20'hFFFFF, 3, 1'b1);
        walk(32'h0040_1ABC, 20'h12345, 0, 1'b1);

        // stray response while idle: R3
        @(posedge clk); #1 inject = 1'b1;
        @(posedge clk); #1 inject = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!resp_valid && !mem_req_valid && req_ready, "R3 stray response ignored",
                  {resp_valid, 3'b0, mem_req_valid, 3'b0, 4'(req_ready)}, 32'h001);
        end
        walk(32'h1234_5678, 20'h0ABCD, 1, 1'b0);

        // random walks
        for (int i = 0; i < 300; i++) begin
            walk($urandom, 20'($urandom), int'($urandom % 4), bit'($urandom % 2));
        end

        check(n_ok > 0, "R7 success seen", 32'(n_ok), 32'd1);
        check(n_f0 > 0, "R5 directory fault seen", 32'(n_f0), 32'd1);
        check(n_f1 > 0, "R6 table fault seen", 32'(n_f1), 32'd1);

        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end
endmodule